// File: doc/BRIEF.md
# DRAM Rank Refresh Scheduler with Opportunistic Throttling

This block decides when each rank of a small DRAM channel gets refreshed. A shared interval timer fires once per programmed average refresh period, and every firing adds one owed refresh to each rank. Owed refreshes are paid back in two ways. While a rank is idle, it is refreshed opportunistically. When a rank has postponed as many refreshes as it is allowed, it is refreshed urgently, in panic mode, whatever its traffic.

Each refresh is offered to the command arbiter through a registered request slot. The slot holds a rank index and a panic flag, and it stays fixed until the arbiter grants it. After a grant, the refreshed rank is held off from activates and further refreshes for a programmed recovery time. A global throttle timer sets a minimum spacing between opportunistic refreshes, which bounds the peak supply current. Panic refreshes bypass the throttle.

All timing inputs count controller command clocks. The refresh interval input is given in units of eight clocks.

Top module: `rfsh_sched`

## Requirements
- R1: Every 8 × `cfg_refi8` clocks, the owed count of every rank rises by one. The count saturates at 8. A `cfg_refi8` of 0 stops the interval timer, and no refresh is then ever requested. With a fresh reset and no grants, the first tick takes effect so that a request can appear 8 × `cfg_refi8` + 2 clocks after reset release.
- R2: A rank whose owed count is nonzero, whose idle flag is set, whose recovery has finished and for which the throttle has expired produces a request with `req_panic` = 0.
- R3: A rank whose owed count equals 8 and whose recovery has finished produces a request with `req_panic` = 1. This happens whatever its idle flag and the throttle state. When any panic request exists, no opportunistic request is selected.
- R4: A grant to rank r drives `act_block[r]` high for exactly `cfg_rfc` clocks, starting the clock after the grant edge. No refresh request for r is raised while it is blocked. The earliest next request for the same rank appears `cfg_rfc` + 2 clocks after the previous one.
- R5: Two opportunistic grants are at least `cfg_thr` clocks apart. A `cfg_thr` of 1 turns the throttle off, so opportunistic requests to different ranks can appear every second clock.
- R6: A `cfg_thr` of 0 behaves exactly like 1. It also sets `cfg_err`, which stays set until reset, even after the field is reprogrammed.
- R7: While `req_valid` is high and `grant` is low, `req_valid`, `req_rank` and `req_panic` do not change. After a grant edge, `req_valid` is low for at least one clock. Each grant removes one owed refresh from the granted rank.
- R8: When several ranks of the winning class request at once, the chosen rank is the first requesting rank at or after the rank that follows the last granted rank, counting upward and wrapping. After reset, the search starts at rank 0.
- R9: After reset, `req_valid`, `act_block` and `cfg_err` are 0 and every owed count is 0.
- R10: Recovery is per rank. A grant to one rank leaves `act_block` of every other rank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rfc | input | 9 | Recovery time after a refresh, in clocks |
| cfg_refi8 | input | 10 | Average refresh interval divided by 8; 0 stops the timer |
| cfg_thr | input | 11 | Minimum clocks between opportunistic refreshes; 1 = off, 0 = illegal |
| rank_idle | input | 4 | Per-rank idle flags, bit r for rank r |
| grant | input | 1 | Arbiter accepts the pending refresh request this clock |
| req_valid | output | 1 | A refresh request is pending |
| req_rank | output | 2 | Binary index of the requested rank |
| req_panic | output | 1 | 1 = panic refresh, 0 = opportunistic |
| act_block | output | 4 | Bit r high while rank r is in refresh recovery |
| cfg_err | output | 1 | Sticky flag: throttle field was programmed to 0 |

## Verification
A table of scenarios varies the interval and the idle mask. This separates the all-busy case, where the first request must be a panic one after eight intervals, from the idle cases, where an opportunistic request follows the first interval and the lowest idle rank wins. Alternating idle ranks under a long throttle, a disabled throttle and an illegal zero throttle distinguishes rate limiting from recovery spacing. A single idle rank with a long recovery shows that only that rank is held off. A long all-busy run with the throttle armed shows that panic requests ignore the throttle and the idle flags, that they rotate through the ranks, that they hold steady while ungranted, and that the owed count stops at 8.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam int OWE_LIMIT_DEF = 8;
  localparam int REFI_SCALE_SH = 3;

  typedef struct packed {
    logic pan;
    logic opp;
  } rank_want_t;
endpackage

// File: rtl/rfsh_ivl_timer.sv
module rfsh_ivl_timer #(
  parameter int REFI_W = 10,
  parameter int SCALE_SH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REFI_W-1:0] cfg_refi8,
  output logic              tick
);
  localparam int CNT_W = REFI_W + SCALE_SH;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] last;
  logic             enabled;

  assign period  = {cfg_refi8, {SCALE_SH{1'b0}}};
  assign last    = period - 1'b1;
  assign enabled = (cfg_refi8 != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (!enabled) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= last) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/rfsh_thr_timer.sv
module rfsh_thr_timer #(
  parameter int THR_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [THR_W-1:0] cfg_thr,
  input  logic             restart,
  output logic             ok,
  output logic             err
);
  logic [THR_W-1:0] cnt_q;
  logic [THR_W-1:0] eff;
  logic             bad_code;

  assign bad_code = (cfg_thr == '0);
  assign eff      = bad_code ? THR_W'(1) : cfg_thr;
  assign ok       = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      err   <= 1'b0;
    end else begin
      if (restart) begin
        cnt_q <= eff - 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (bad_code) begin
        err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rfsh_rank_ctl.sv
module rfsh_rank_ctl
  import rfsh_pkg::*;
#(
  parameter int RFC_W = 9,
  parameter int OWE_LIMIT = OWE_LIMIT_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             idle,
  input  logic             thr_ok,
  input  logic             take,
  input  logic [RFC_W-1:0] cfg_rfc,
  output rank_want_t       want,
  output logic             blocked
);
  localparam int OWE_W = $clog2(OWE_LIMIT + 1);
  localparam logic [OWE_W-1:0] OWE_TOP = OWE_W'(OWE_LIMIT);

  logic [OWE_W-1:0] owe_q;
  logic [RFC_W-1:0] rec_q;
  logic             recovered;

  assign recovered = (rec_q == '0);
  assign want.pan  = (owe_q == OWE_TOP) && recovered;
  assign want.opp  = (owe_q != '0) && idle && thr_ok && recovered;

  always_ff @(posedge clk) begin
    if (rst) begin
      owe_q   <= '0;
      rec_q   <= '0;
      blocked <= 1'b0;
    end else begin
      case ({tick, take})
        2'b10: if (owe_q != OWE_TOP) owe_q <= owe_q + 1'b1;
        2'b01: if (owe_q != '0) owe_q <= owe_q - 1'b1;
        default: ;
      endcase
      if (take) begin
        rec_q   <= cfg_rfc;
        blocked <= (cfg_rfc != '0);
      end else if (rec_q != '0) begin
        rec_q   <= rec_q - 1'b1;
        blocked <= (rec_q != RFC_W'(1));
      end
    end
  end
endmodule

// File: rtl/rfsh_rr_pick.sv
module rfsh_rr_pick #(
  parameter int N = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pan_vec,
  input  logic [N-1:0]  opp_vec,
  input  logic [IW-1:0] ptr,
  output logic          any,
  output logic          is_pan,
  output logic [IW-1:0] idx
);
  logic [N-1:0] cand;
  logic         found;
  int           j;

  always_comb begin
    is_pan = |pan_vec;
    cand   = is_pan ? pan_vec : opp_vec;
    any    = |cand;
    idx    = '0;
    found  = 1'b0;
    j      = 0;
    for (int off = 0; off < N; off++) begin
      j = int'(ptr) + off;
      if (j >= N) j = j - N;
      if (!found && cand[IW'(j)]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int RFC_W = 9,
  parameter int REFI_W = 10,
  parameter int THR_W = 11,
  parameter int OWE_LIMIT = OWE_LIMIT_DEF,
  localparam int IW = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [RFC_W-1:0]     cfg_rfc,
  input  logic [REFI_W-1:0]    cfg_refi8,
  input  logic [THR_W-1:0]     cfg_thr,
  input  logic [NUM_RANKS-1:0] rank_idle,
  input  logic                 grant,
  output logic                 req_valid,
  output logic [IW-1:0]        req_rank,
  output logic                 req_panic,
  output logic [NUM_RANKS-1:0] act_block,
  output logic                 cfg_err
);
  logic                 tick;
  logic                 thr_ok;
  logic                 accepted;
  logic [NUM_RANKS-1:0] take;
  logic [NUM_RANKS-1:0] pan_vec;
  logic [NUM_RANKS-1:0] opp_vec;
  logic                 pick_any;
  logic                 pick_pan;
  logic [IW-1:0]        pick_idx;
  logic [IW-1:0]        ptr_q;

  assign accepted = req_valid && grant;

  rfsh_ivl_timer #(
    .REFI_W  (REFI_W),
    .SCALE_SH(REFI_SCALE_SH)
  ) u_ivl (
    .clk      (clk),
    .rst      (rst),
    .cfg_refi8(cfg_refi8),
    .tick     (tick)
  );

  rfsh_thr_timer #(
    .THR_W(THR_W)
  ) u_thr (
    .clk    (clk),
    .rst    (rst),
    .cfg_thr(cfg_thr),
    .restart(accepted && !req_panic),
    .ok     (thr_ok),
    .err    (cfg_err)
  );

  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_rank
    rank_want_t want;
    assign take[g]    = accepted && (req_rank == IW'(g));
    assign pan_vec[g] = want.pan;
    assign opp_vec[g] = want.opp;

    rfsh_rank_ctl #(
      .RFC_W    (RFC_W),
      .OWE_LIMIT(OWE_LIMIT)
    ) u_rank (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .idle   (rank_idle[g]),
      .thr_ok (thr_ok),
      .take   (take[g]),
      .cfg_rfc(cfg_rfc),
      .want   (want),
      .blocked(act_block[g])
    );
  end

  rfsh_rr_pick #(
    .N (NUM_RANKS),
    .IW(IW)
  ) u_pick (
    .pan_vec(pan_vec),
    .opp_vec(opp_vec),
    .ptr    (ptr_q),
    .any    (pick_any),
    .is_pan (pick_pan),
    .idx    (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_rank  <= '0;
      req_panic <= 1'b0;
      ptr_q     <= '0;
    end else if (req_valid) begin
      if (grant) begin
        req_valid <= 1'b0;
        ptr_q     <= (req_rank == IW'(NUM_RANKS - 1)) ? '0 : req_rank + 1'b1;
      end
    end else if (pick_any) begin
      req_valid <= 1'b1;
      req_rank  <= pick_idx;
      req_panic <= pick_pan;
    end
  end
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter int N = 4,
  parameter int RFC_W = 9,
  parameter int THR_W = 11,
  parameter int IW = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             grant,
  input logic             req_valid,
  input logic [IW-1:0]    req_rank,
  input logic             req_panic,
  input logic [N-1:0]     act_block,
  input logic [RFC_W-1:0] cfg_rfc,
  input logic [THR_W-1:0] cfg_thr,
  input logic             cfg_err
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_valid && !grant |=> req_valid && $stable(req_rank) && $stable(req_panic)); // R7
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    req_valid && grant |=> !req_valid); // R7
  AST_BLOCK_START: assert property (@(posedge clk) disable iff (rst)
    req_valid && grant && (cfg_rfc != '0) |=> act_block[$past(req_rank)]); // R4
  AST_NO_REQ_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) |-> !(|($past(act_block) & (N'(1) << req_rank)))); // R4
  AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    (cfg_thr == '0) |=> cfg_err); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err); // R6
endmodule

bind rfsh_sched rfsh_sched_chk #(
  .N    (NUM_RANKS),
  .RFC_W(RFC_W),
  .THR_W(THR_W),
  .IW   (IW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .grant    (grant),
  .req_valid(req_valid),
  .req_rank (req_rank),
  .req_panic(req_panic),
  .act_block(act_block),
  .cfg_rfc  (cfg_rfc),
  .cfg_thr  (cfg_thr),
  .cfg_err  (cfg_err)
);

// File: tb/rfsh_sched_test.sv
`timescale 1ns/1ps
module rfsh_sched_test;
  localparam int N = 4;
  localparam int RFC_W = 9;
  localparam int REFI_W = 10;
  localparam int THR_W = 11;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [RFC_W-1:0] cfg_rfc = '0;
  logic [REFI_W-1:0] cfg_refi8 = '0;
  logic [THR_W-1:0] cfg_thr = 11'd1;
  logic [N-1:0]     rank_idle = '0;
  logic             grant = 1'b0;
  logic             req_valid;
  logic [1:0]       req_rank;
  logic             req_panic;
  logic [N-1:0]     act_block;
  logic             cfg_err;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else cyc <= cyc + 1;
  end

  rfsh_sched #(
    .NUM_RANKS(N), .RFC_W(RFC_W), .REFI_W(REFI_W), .THR_W(THR_W)
  ) uut (
    .clk(clk), .rst(rst), .cfg_rfc(cfg_rfc), .cfg_refi8(cfg_refi8),
    .cfg_thr(cfg_thr), .rank_idle(rank_idle), .grant(grant),
    .req_valid(req_valid), .req_rank(req_rank), .req_panic(req_panic),
    .act_block(act_block), .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic [9:0] refi8;
    logic [3:0] idle;
    logic [1:0] rank;
    logic       pan;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{10'd1, 4'b0000, 2'd0, 1'b1},
    '{10'd2, 4'b0100, 2'd2, 1'b0},
    '{10'd3, 4'b1010, 2'd1, 1'b0},
    '{10'd1, 4'b1000, 2'd3, 1'b0},
    '{10'd4, 4'b0000, 2'd0, 1'b1},
    '{10'd2, 4'b0110, 2'd1, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic do_reset(input int refi8, input int thr, input int rfc, input logic [3:0] idl);
    @(negedge clk);
    rst = 1'b1;
    grant = 1'b0;
    cfg_refi8 = REFI_W'(refi8);
    cfg_thr = THR_W'(thr);
    cfg_rfc = RFC_W'(rfc);
    rank_idle = idl;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_req(output int at, input int limit, input string tag);
    int n;
    n = 0;
    while (!req_valid && n < limit) begin
      @(negedge clk);
      n++;
    end
    at = cyc;
    if (!req_valid) chk(1'b0, tag, 0, 1);
  endtask

  task automatic give_grant();
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    #950000.0;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a1, a2, a3, cnt, exp_at;
    bit seen, others;
    logic [1:0] r0;
    logic p0;

    // Reset state (R9)
    do_reset(1, 1, 3, 4'b1111);
    @(negedge clk);
    chk(req_valid == 1'b0, "R9 req_valid", int'(req_valid), 0);
    chk(act_block == '0, "R9 act_block", int'(act_block), 0);
    chk(cfg_err == 1'b0, "R9 cfg_err", int'(cfg_err), 0);

    // Vector table: first request time, rank and class (R1 R2 R3 R8)
    for (int i = 0; i < 6; i++) begin
      do_reset(int'(VECS[i].refi8), 1, 3, VECS[i].idle);
      exp_at = VECS[i].pan ? 64 * int'(VECS[i].refi8) + 2 : 8 * int'(VECS[i].refi8) + 2;
      wait_req(a1, exp_at + 20, "R1 first request missing");
      chk(a1 == exp_at, VECS[i].pan ? "R1 R3 first panic time" : "R1 R2 first opp time", a1, exp_at);
      chk(req_rank == VECS[i].rank, "R8 first rank", int'(req_rank), int'(VECS[i].rank));
      chk(req_panic == VECS[i].pan, VECS[i].pan ? "R3 panic flag" : "R2 panic flag", int'(req_panic), int'(VECS[i].pan));
    end

    // Interval timer stopped (R1)
    do_reset(0, 1, 3, 4'b1111);
    seen = 1'b0;
    repeat (300) begin
      @(negedge clk);
      if (req_valid) seen = 1'b1;
    end
    chk(!seen, "R1 refi8=0 request", int'(seen), 0);

    // Recovery per rank (R4 R10)
    do_reset(4, 1, 5, 4'b0000);
    wait_until(100);
    rank_idle = 4'b0001;
    wait_req(a1, 50, "R4 request missing");
    chk(req_rank == 2'd0, "R2 idle rank", int'(req_rank), 0);
    give_grant();
    cnt = 0;
    others = 1'b0;
    while (act_block[0] && cnt < 50) begin
      if (act_block[3:1] != 3'b000) others = 1'b1;
      cnt++;
      @(negedge clk);
    end
    chk(cnt == 5, "R4 block length", cnt, 5);
    chk(!others, "R10 other ranks blocked", int'(others), 0);
    wait_req(a2, 50, "R4 second request missing");
    chk(a2 - a1 == 7, "R4 same-rank spacing", a2 - a1, 7);

    // Throttle active (R5 R8)
    do_reset(4, 20, 2, 4'b0000);
    wait_until(100);
    rank_idle = 4'b0011;
    wait_req(a1, 50, "R5 request missing");
    chk(req_rank == 2'd0, "R8 rr first", int'(req_rank), 0);
    give_grant();
    wait_req(a2, 50, "R5 request missing");
    chk(a2 - a1 == 21, "R5 throttle spacing", a2 - a1, 21);
    chk(req_rank == 2'd1, "R8 rr second", int'(req_rank), 1);
    give_grant();
    wait_req(a3, 50, "R5 request missing");
    chk(a3 - a2 == 21, "R5 throttle spacing 2", a3 - a2, 21);
    chk(req_rank == 2'd0, "R8 rr wrap", int'(req_rank), 0);

    // Throttle off (R5) and illegal zero (R6)
    for (int t = 1; t >= 0; t--) begin
      do_reset(4, t, 2, 4'b0000);
      wait_until(100);
      rank_idle = 4'b0011;
      wait_req(a1, 50, "R5 request missing");
      give_grant();
      wait_req(a2, 50, "R5 request missing");
      chk(a2 - a1 == 2, t == 1 ? "R5 throttle off spacing" : "R6 zero acts as one", a2 - a1, 2);
      chk(req_rank == 2'd1, "R8 alternate rank", int'(req_rank), 1);
      chk(cfg_err == (t == 0), "R6 cfg_err value", int'(cfg_err), int'(t == 0));
    end
    cfg_thr = 11'd5;
    repeat (3) @(negedge clk);
    chk(cfg_err == 1'b1, "R6 cfg_err sticky", int'(cfg_err), 1);
    do_reset(4, 5, 2, 4'b0000);
    @(negedge clk);
    chk(cfg_err == 1'b0, "R9 cfg_err cleared", int'(cfg_err), 0);

    // Panic ignores throttle and idle, rotates, holds (R3 R7 R8)
    do_reset(1, 1000, 3, 4'b0010);
    wait_req(a1, 40, "R2 request missing");
    chk(a1 == 10 && req_rank == 2'd1 && !req_panic, "R2 opp rank1", a1, 10);
    give_grant();
    wait_req(a2, 200, "R3 panic missing");
    chk(a2 == 66, "R3 panic time under throttle", a2, 66);
    chk(req_rank == 2'd2, "R8 panic after last grant", int'(req_rank), 2);
    chk(req_panic == 1'b1, "R3 panic flag", int'(req_panic), 1);
    r0 = req_rank;
    p0 = req_panic;
    repeat (6) @(negedge clk);
    chk(req_valid && req_rank == r0 && req_panic == p0, "R7 held while ungranted", int'(req_rank), int'(r0));
    give_grant();
    chk(req_valid == 1'b0, "R7 drop after grant", int'(req_valid), 0);
    wait_req(a3, 10, "R3 panic missing");
    chk(req_rank == 2'd3 && req_panic, "R8 next panic rank", int'(req_rank), 3);

    // Saturation at 8 (R1 R7)
    do_reset(100, 1, 1, 4'b0000);
    wait_until(7250);
    for (int k = 0; k < 4; k++) begin
      wait_req(a1, 20, "R3 panic missing");
      chk(int'(req_rank) == k && req_panic, "R8 panic order", int'(req_rank), k);
      give_grant();
    end
    seen = 1'b0;
    repeat (50) begin
      @(negedge clk);
      if (req_valid) seen = 1'b1;
    end
    chk(!seen, "R1 owed count saturates", int'(seen), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule